// File: doc/BRIEF.md
# Flash Write-Protection Range Checker

This block is an access-policy gate in front of a serial flash sequencer. Each flash cycle arrives as a request with a 24-bit byte address, a flag that marks it as a write or erase, and a go strobe. In the cycle after the strobe, the block either passes a one-cycle start pulse to the sequencer or refuses the cycle. A refused cycle produces no start pulse. It raises a sticky blocked-access status flag instead.

Two mechanisms set the policy. The first is a set of protected-range slots. Each slot packs an enable bit, a base page and a limit page into one 32-bit register, at 4 KiB granularity. Write and erase cycles that land inside any enabled slot are refused. The second is a barrier address. Any cycle below the barrier is refused, whether it reads or writes. The barrier register reads back with its top byte forced to ones.

A status register carries two bits. One is the blocked-access flag, which is cleared by writing a one to it. The other is a configuration lock. Once the lock is set, the slots and the barrier are frozen until reset. All registers sit behind a simple select/write-data port with a combinational read-back.

Top module: `flash_guard`

## Requirements
- R1: After reset, every range slot reads 0, the barrier reads 0xFF000000, the status reads 0, and no start pulse is given.
- R2: A go strobe whose cycle breaks no rule gives `seqStart` high for exactly the one cycle after the strobe, and leaves `accessBlocked` unchanged.
- R3: A range slot (select 0 to 3) holds an enable in bit 31, a base page in bits 27:16 and a limit page in bits 11:0. A page is address bits 23:12. A write cycle whose page lies in [base, limit] inclusive, in an enabled slot, is refused: there is no start pulse and `accessBlocked` is set in the cycle after the strobe.
- R4: A slot with bit 31 clear has no effect. Read cycles (`reqWrite` low) are never refused by any slot.
- R5: The barrier register (select 4) stores write-data bits 23:0 and reads back as 0xFF in bits 31:24 followed by the stored value. Any cycle, read or write, whose address is below the stored value is refused.
- R6: Status (select 5) holds the blocked flag in bit 0 and the lock in bit 1. The flag stays set through later permitted cycles. Writing 1 to bit 0 clears it, and writing 0 to bit 0 leaves it set.
- R7: Writing 1 to status bit 1 sets the lock. While locked, writes to the slots and to the barrier are ignored. Writing 0 to bit 1 does not clear the lock. Only reset clears it.
- R8: While locked, the blocked flag can still be cleared by writing 1 to status bit 0, and the frozen policy keeps being applied.
- R9: The slot bits outside the enable, base and limit fields (bits 30:28 and 15:12) read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgSel | input | 3 | Register select: 0 to 3 range slots, 4 barrier, 5 status |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Combinational read-back of the selected register |
| reqGo | input | 1 | Cycle request strobe |
| reqAddr | input | 24 | Byte address of the requested cycle |
| reqWrite | input | 1 | High for a write or erase cycle |
| seqStart | output | 1 | One-cycle start pulse to the sequencer |
| accessBlocked | output | 1 | Sticky blocked-access flag |
| cfgLocked | output | 1 | Configuration lock state |

## Verification
The bench uses the default parameters: four slots, a 24-bit address and 4 KiB pages. This puts all four slot selects, the barrier at select 4 and the status at select 5 within reach of one 3-bit select. The 12-bit page fields let the bench probe both inclusive edges of a slot. It also covers a single-page slot, and an address just below and at the barrier. Because the slot count is small, the bench can also fill a spare slot with all ones and read back that the unused bits drop out.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  // Strobes from the control module into the datapath
  typedef struct packed {
    logic rangeWe;
    logic barWe;
  } dpStrobe_t;

  // Status register bit positions
  localparam int STAT_FLAG_BIT = 0;
  localparam int STAT_LOCK_BIT = 1;

  // Range slot field positions
  localparam int RNG_EN_BIT   = 31;
  localparam int RNG_BASE_LSB = 16;
  localparam int RNG_LIM_LSB  = 0;

endpackage

// File: rtl/flash_guard_range_cmp.sv
module flash_guard_range_cmp #(
  parameter int PAGE_W = 12
) (
  input  logic              slotEn,
  input  logic [PAGE_W-1:0] basePage,
  input  logic [PAGE_W-1:0] limitPage,
  input  logic [PAGE_W-1:0] reqPage,
  output logic              hit
);
  // Inclusive on both ends
  always_comb begin
    hit = slotEn && (reqPage >= basePage) && (reqPage <= limitPage);
  end
endmodule

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int ADDR_W     = 24,
  parameter int GRAN_BITS  = 12,
  parameter int SEL_W      = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [31:0]       cfgWdata,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              lockIn,
  input  logic              flagIn,
  output logic [31:0]       cfgRdata,
  output logic              rangeViol,
  output logic              barViol
);
  localparam int PAGE_W = ADDR_W - GRAN_BITS;
  localparam int TOP_W  = 32 - ADDR_W;

  logic              slotEn    [NUM_RANGES];
  logic [PAGE_W-1:0] slotBase  [NUM_RANGES];
  logic [PAGE_W-1:0] slotLimit [NUM_RANGES];
  logic [NUM_RANGES-1:0] slotHit;
  logic [ADDR_W-1:0] barReg;
  logic [PAGE_W-1:0] reqPage;

  assign reqPage = reqAddr[ADDR_W-1:GRAN_BITS];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotEn[g]    <= 1'b0;
        slotBase[g]  <= '0;
        slotLimit[g] <= '0;
      end else if (strobe.rangeWe && cfgSel == SEL_W'(g)) begin
        slotEn[g]    <= cfgWdata[RNG_EN_BIT];
        slotBase[g]  <= cfgWdata[RNG_BASE_LSB +: PAGE_W];
        slotLimit[g] <= cfgWdata[RNG_LIM_LSB +: PAGE_W];
      end
    end

    flash_guard_range_cmp #(.PAGE_W(PAGE_W)) u_cmp (
      .slotEn    (slotEn[g]),
      .basePage  (slotBase[g]),
      .limitPage (slotLimit[g]),
      .reqPage   (reqPage),
      .hit       (slotHit[g])
    );

    // R7
    range_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(lockIn) |-> ($stable(slotEn[g]) && $stable(slotBase[g]) && $stable(slotLimit[g])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      barReg <= '0;
    end else if (strobe.barWe) begin
      barReg <= cfgWdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    rangeViol = reqWrite && (|slotHit);
    barViol   = reqAddr < barReg;
  end

  always_comb begin
    cfgRdata = '0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (cfgSel == SEL_W'(i)) begin
        cfgRdata[RNG_EN_BIT]                = slotEn[i];
        cfgRdata[RNG_BASE_LSB +: PAGE_W]    = slotBase[i];
        cfgRdata[RNG_LIM_LSB +: PAGE_W]     = slotLimit[i];
      end
    end
    if (cfgSel == SEL_W'(NUM_RANGES)) begin
      cfgRdata = {{TOP_W{1'b1}}, barReg};
    end
    if (cfgSel == SEL_W'(NUM_RANGES + 1)) begin
      cfgRdata[STAT_FLAG_BIT] = flagIn;
      cfgRdata[STAT_LOCK_BIT] = lockIn;
    end
  end

  // R7
  bar_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockIn) |-> $stable(barReg));

endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int SEL_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             clrBit,
  input  logic             lockBit,
  input  logic             reqGo,
  input  logic             rangeViol,
  input  logic             barViol,
  output dpStrobe_t        strobe,
  output logic             seqStart,
  output logic             blockedFlag,
  output logic             lockQ
);
  localparam logic [SEL_W-1:0] SEL_BAR  = SEL_W'(NUM_RANGES);
  localparam logic [SEL_W-1:0] SEL_STAT = SEL_W'(NUM_RANGES + 1);

  logic statWe;
  logic goViol;

  always_comb begin
    strobe.rangeWe = cfgWe && !lockQ && (cfgSel < SEL_BAR);
    strobe.barWe   = cfgWe && !lockQ && (cfgSel == SEL_BAR);
    statWe         = cfgWe && (cfgSel == SEL_STAT);
    goViol         = rangeViol || barViol;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqStart    <= 1'b0;
      blockedFlag <= 1'b0;
      lockQ       <= 1'b0;
    end else begin
      seqStart <= reqGo && !goViol;
      if (reqGo && goViol) begin
        blockedFlag <= 1'b1;
      end else if (statWe && clrBit) begin
        blockedFlag <= 1'b0;
      end
      if (statWe && lockBit) begin
        lockQ <= 1'b1;
      end
    end
  end

  // R2
  start_after_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |-> $past(reqGo));

  // R3
  start_blk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |-> !$rose(blockedFlag));

  // R6
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockedFlag) |-> $past(reqGo));

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockQ) |-> lockQ);

endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 4,
  parameter int ADDR_W     = 24,
  parameter int GRAN_BITS  = 12,
  localparam int SEL_W     = $clog2(NUM_RANGES + 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic [31:0]       cfgWdata,
  output logic [31:0]       cfgRdata,
  input  logic              reqGo,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  output logic              seqStart,
  output logic              accessBlocked,
  output logic              cfgLocked
);
  dpStrobe_t strobe;
  logic rangeViol;
  logic barViol;

  flash_guard_ctrl #(.NUM_RANGES(NUM_RANGES), .SEL_W(SEL_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWe       (cfgWe),
    .cfgSel      (cfgSel),
    .clrBit      (cfgWdata[STAT_FLAG_BIT]),
    .lockBit     (cfgWdata[STAT_LOCK_BIT]),
    .reqGo       (reqGo),
    .rangeViol   (rangeViol),
    .barViol     (barViol),
    .strobe      (strobe),
    .seqStart    (seqStart),
    .blockedFlag (accessBlocked),
    .lockQ       (cfgLocked)
  );

  flash_guard_dp #(
    .NUM_RANGES (NUM_RANGES),
    .ADDR_W     (ADDR_W),
    .GRAN_BITS  (GRAN_BITS),
    .SEL_W      (SEL_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgSel    (cfgSel),
    .cfgWdata  (cfgWdata),
    .reqAddr   (reqAddr),
    .reqWrite  (reqWrite),
    .lockIn    (cfgLocked),
    .flagIn    (accessBlocked),
    .cfgRdata  (cfgRdata),
    .rangeViol (rangeViol),
    .barViol   (barViol)
  );
endmodule

// File: tb/flash_guard_bench.sv
`timescale 1ns/1ps
module flash_guard_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        reqGo = 1'b0;
  logic [23:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        seqStart;
  logic        accessBlocked;
  logic        cfgLocked;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  flash_guard u_flash_guard (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .reqGo(reqGo), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .seqStart(seqStart), .accessBlocked(accessBlocked), .cfgLocked(cfgLocked)
  );

  // {address, write, expected start}
  localparam logic [25:0] VEC [0:13] = '{
    {24'h005000, 1'b1, 1'b1},
    {24'h010000, 1'b1, 1'b0},
    {24'h01FFFF, 1'b1, 1'b0},
    {24'h020000, 1'b1, 1'b1},
    {24'h00FFFF, 1'b1, 1'b1},
    {24'h010000, 1'b0, 1'b1},
    {24'h080000, 1'b1, 1'b0},
    {24'h080FFF, 1'b1, 1'b0},
    {24'h081000, 1'b1, 1'b1},
    {24'h07FFFF, 1'b1, 1'b1},
    {24'h250000, 1'b1, 1'b1},
    {24'h003FFF, 1'b0, 1'b0},
    {24'h004000, 1'b0, 1'b1},
    {24'h000000, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgWdata = data;
    @(negedge clk);
    cfgWe = 1'b0; cfgWdata = '0;
  endtask

  task automatic cfgRead(input logic [2:0] sel, output logic [31:0] data);
    @(negedge clk);
    cfgSel = sel;
    #1 data = cfgRdata;
  endtask

  // Leaves the bench at the negedge after the decision edge
  task automatic runReq(input logic [23:0] addr, input logic wr);
    @(negedge clk);
    reqAddr = addr; reqWrite = wr; reqGo = 1'b1;
    @(negedge clk);
    reqGo = 1'b0;
  endtask

  task automatic doReset;
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    logic [31:0] rd;
    doReset();

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      cfgRead(3'(i), rd);
      chk("R1 slot reset", rd, 32'h0);
    end
    cfgRead(3'd4, rd);
    chk("R1 barrier reset", rd, 32'hFF000000);
    cfgRead(3'd5, rd);
    chk("R1 status reset", rd, 32'h0);
    chk("R1 no start", {31'b0, seqStart}, 32'h0);

    // R9 unused slot bits read zero
    cfgWrite(3'd3, 32'hFFFFFFFF);
    cfgRead(3'd3, rd);
    chk("R9 slot field mask", rd, 32'h8FFF0FFF);
    cfgWrite(3'd3, 32'h0);

    // Policy setup: slot0 pages 0x010..0x01F, slot1 page 0x080, slot2 disabled
    cfgWrite(3'd0, 32'h8010001F);
    cfgWrite(3'd1, 32'h80800080);
    cfgWrite(3'd2, 32'h020002FF);
    // R5 barrier read-back with top byte forced
    cfgWrite(3'd4, 32'h12004000);
    cfgRead(3'd4, rd);
    chk("R5 barrier readback", rd, 32'hFF004000);

    // Vector table: R2 permitted, R3 range hits, R4 disabled slot and reads, R5 barrier
    for (int v = 0; v < 14; v++) begin
      runReq(VEC[v][25:2], VEC[v][1]);
      chk($sformatf("R2/R3/R4/R5 vec%0d start", v), {31'b0, seqStart}, {31'b0, VEC[v][0]});
      chk($sformatf("R3/R5 vec%0d blocked", v), {31'b0, accessBlocked}, {31'b0, ~VEC[v][0]});
      @(negedge clk);
      chk($sformatf("R2 vec%0d pulse width", v), {31'b0, seqStart}, 32'h0);
      if (!VEC[v][0]) cfgWrite(3'd5, 32'h1);
    end

    // R6 sticky flag, write-0 keeps, write-1 clears
    runReq(24'h010000, 1'b1);
    runReq(24'h005000, 1'b1);
    chk("R6 flag sticky through permitted", {31'b0, accessBlocked}, 32'h1);
    chk("R2 permitted with flag set", {31'b0, seqStart}, 32'h1);
    cfgWrite(3'd5, 32'h0);
    cfgRead(3'd5, rd);
    chk("R6 write zero keeps flag", rd, 32'h1);
    cfgWrite(3'd5, 32'h1);
    cfgRead(3'd5, rd);
    chk("R6 write one clears flag", rd, 32'h0);

    // R7 lock
    cfgWrite(3'd5, 32'h2);
    chk("R7 lock set", {31'b0, cfgLocked}, 32'h1);
    cfgWrite(3'd0, 32'h0);
    cfgRead(3'd0, rd);
    chk("R7 slot frozen", rd, 32'h8010001F);
    cfgWrite(3'd4, 32'h0);
    cfgRead(3'd4, rd);
    chk("R7 barrier frozen", rd, 32'hFF004000);
    cfgWrite(3'd5, 32'h0);
    chk("R7 zero write keeps lock", {31'b0, cfgLocked}, 32'h1);

    // R8 policy applied and flag clearable while locked
    runReq(24'h018000, 1'b1);
    chk("R8 locked policy blocks", {31'b0, seqStart}, 32'h0);
    chk("R8 locked flag set", {31'b0, accessBlocked}, 32'h1);
    cfgWrite(3'd5, 32'h1);
    cfgRead(3'd5, rd);
    chk("R8 clear while locked", rd, 32'h2);

    // R7 only reset clears lock
    doReset();
    chk("R7 lock cleared by reset", {31'b0, cfgLocked}, 32'h0);
    cfgRead(3'd0, rd);
    chk("R1 slot cleared by reset", rd, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule